// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address into a real address by walking a hashed page table held in an external memory. The top four address bits pick one of sixteen segment registers. The segment register supplies a 24-bit segment ID, a protection-key selection and two refusal flags. The walker turns the segment ID and the page index into a group address and reads the group's eight two-word entries one word at a time. If nothing matches, it repeats the search in the secondary group. It then applies the protection key to the matching entry and returns the real address, the read and write permission, or a fault code.

On a granted access the walker sets the referenced bit and, on a write, the changed bit, and stores word 1 of the entry back to memory when the word changed. A page whose changed bit is still clear is returned without write permission. The first store to that page therefore faults and comes back through the walker, which then sets the changed bit. The segment registers load through a small write port. One request is handled at a time, and `done` marks the cycle in which the result outputs become valid.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is `req_addr[31:28]`. The segment ID is its bits 23:0 and the page index is `req_addr[27:12]`. The protection key is 1 when segment bit 29 is set and `req_user`=1, or when segment bit 30 is set and `req_user`=0. In all other cases the key is 0.
- R2: When segment bit 31 is set, every access (fetch or data) finishes with fault code 4 (direct-store) and reads no memory.
- R3: When segment bit 28 is set and `req_fetch`=1, the access finishes with fault code 3 (no-execute).
- R4: The primary hash is ((segment ID XOR page index) AND 0x7FFFF) << 6. The group address is (`table_reg` AND 0xFFFF0000) OR (hash AND ((`table_reg[8:0]` << 16) OR 0xFFC0)). Entry k of a group has word 0 at group+8k and word 1 at group+8k+4.
- R5: The secondary hash is (NOT primary hash) AND 0x01FFFFC0. The secondary group is searched only when the primary group has no matching entry. If both groups miss, the fault code is 1 (not found).
- R6: An entry matches only when word 0 bit 31 is 1, word 0 bit 6 equals the pass (0 primary, 1 secondary), bits 30:7 equal the segment ID and bits 5:0 equal page index bits 15:10.
- R7: The protection field is word 1 bits 1:0 (pp). With key 0, read is allowed and write is allowed unless pp=3. With key 1, pp=0 allows nothing, pp=2 allows read and write, and pp=1 or pp=3 allow read only. A denied access finishes with fault code 2.
- R8: When several entries of the searched group match and their word 1 values differ under mask 0xFFFFF07B, the fault code is 5. Entries that differ only outside that mask are accepted, and the first matching entry is used.
- R9: On a granted access, word 1 gets bit 8 (referenced) set and, for a write, bit 7 (changed) set. It is written back to its address exactly once, and only when the value changed.
- R10: `perm_write` is 1 only when pp allows writing and the updated changed bit is 1. A granted write therefore always reports write permission.
- R11: On success, `fault`=0, `real_addr` = {word 1 bits 31:12, `req_addr[11:0]`}, and `perm_read` reports the read permission.
- R12: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0. `done` is high for one cycle per accepted request. A `req_valid` seen while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_idx | input | 4 | Segment register to write |
| seg_wr_data | input | 32 | Segment register write value |
| table_reg | input | 32 | Table base (31:16) and hash mask extension (8:0), sampled on accept |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | 1 = write access |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 3 | 0 ok, 1 not found, 2 protection, 3 no-execute, 4 direct-store, 5 conflict |
| real_addr | output | 32 | Translated address |
| perm_read | output | 1 | Page readable |
| perm_write | output | 1 | Page writable |
| mem_rd_en | output | 1 | Table read strobe; data expected on mem_rdata one cycle later |
| mem_wr_en | output | 1 | Table write strobe |
| mem_addr | output | 32 | Table byte address |
| mem_wdata | output | 32 | Write-back value of word 1 |
| mem_rdata | input | 32 | Table read data |

## Verification
Directed cases place one matching entry in the primary or the secondary group. Next to it they put near-miss entries that differ only in the valid bit or the pass selector, so that a correct two-pass search can be told apart from one that ignores the selector or skips the second group. Protection is tried at both privilege levels over the pp values. Read, then write, then read again on one page separates the referenced-only update, the changed-bit update and the no-write-back case. Constrained-random rounds mix segment flags, table masks, distractor entries and duplicate matches, and each round is compared with a bench model of the walk, including the written-back word.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_MISS   = 3'd1,
    FLT_PROT   = 3'd2,
    FLT_NOEXEC = 3'd3,
    FLT_DSEG   = 3'd4,
    FLT_MULTI  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WAIT, S_EVAL, S_WB, S_DONE
  } walk_state_e;

  localparam int SEG_DIRECT = 31;
  localparam int SEG_SUPKEY = 30;
  localparam int SEG_USRKEY = 29;
  localparam int SEG_NOEXEC = 28;
  localparam int PTE_VALID  = 31;
  localparam int PTE_SEL    = 6;
  localparam int PTE_REF    = 8;
  localparam int PTE_CHG    = 7;
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;
endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile #(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 32,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] regs [NUM_SEG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int HASH_W = 19,
  parameter int LINE_SH = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pgidx,
  input  logic [31:0]       table_reg,
  input  logic              second,
  output logic [31:0]       group_addr
);
  localparam int PAD_W = 32 - HASH_W - LINE_SH;
  logic [HASH_W-1:0] mix;
  logic [31:0] prim, hsel, mask;

  always_comb begin
    mix  = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pgidx};
    prim = {{PAD_W{1'b0}}, mix, {LINE_SH{1'b0}}};
    hsel = second ? (~prim & 32'h01FF_FFC0) : prim;
    mask = {7'b0, table_reg[8:0], 16'hFFC0};
    group_addr = {table_reg[31:16], 16'h0000} | (hsel & mask);
  end
endmodule

// File: rtl/hpt_perm.sv
module hpt_perm (
  input  logic       key,
  input  logic [1:0] pp,
  output logic       rd_ok,
  output logic       wr_ok
);
  always_comb begin
    if (!key) begin
      rd_ok = 1'b1;
      wr_ok = (pp != 2'd3);
    end else begin
      rd_ok = (pp != 2'd0);
      wr_ok = (pp == 2'd2);
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int NUM_SEG  = 16,
  parameter int NUM_WAYS = 8,
  localparam int SEG_SEL_W = $clog2(NUM_SEG),
  localparam int IDX_W     = $clog2(2 * NUM_WAYS),
  localparam int SLOT_W    = $clog2(NUM_WAYS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 seg_wr_en,
  input  logic [SEG_SEL_W-1:0] seg_wr_idx,
  input  logic [31:0]          seg_wr_data,
  input  logic [31:0]          table_reg,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic                 req_write,
  input  logic                 req_fetch,
  input  logic                 req_user,
  output logic                 busy,
  output logic                 done,
  output logic [2:0]           fault,
  output logic [31:0]          real_addr,
  output logic                 perm_read,
  output logic                 perm_write,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [31:0]          mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(2 * NUM_WAYS - 1);

  walk_state_e state;
  logic [31:0] ea_q, seg_q, tr_q, w0_q, keep_q, wb_addr_q, wb_data_q, ra_q;
  logic wr_q, fetch_q, user_q, pass_q, hit_q, multi_q, pr_q, pw_q;
  logic [IDX_W-1:0] idx_q;
  logic [SLOT_W-1:0] slot_q;
  fault_e fault_q;

  logic [31:0] seg_rd, group_addr, word_addr, new_w1;
  logic [23:0] vsid;
  logic [15:0] pgidx;
  logic key, entry_hit, can_rd, can_wr, granted;

  hpt_segfile #(.NUM_SEG(NUM_SEG), .SEG_W(32)) u_seg (
    .clk(clk), .rst(rst), .wr_en(seg_wr_en), .wr_idx(seg_wr_idx),
    .wr_data(seg_wr_data), .rd_idx(req_addr[31 -: SEG_SEL_W]), .rd_data(seg_rd)
  );

  assign vsid  = seg_q[23:0];
  assign pgidx = ea_q[27:12];
  assign key   = user_q ? seg_q[SEG_USRKEY] : seg_q[SEG_SUPKEY];

  hpt_hash u_hash (
    .vsid(vsid), .pgidx(pgidx), .table_reg(tr_q), .second(pass_q),
    .group_addr(group_addr)
  );

  hpt_perm u_perm (.key(key), .pp(keep_q[1:0]), .rd_ok(can_rd), .wr_ok(can_wr));

  assign entry_hit = w0_q[PTE_VALID] && (w0_q[PTE_SEL] == pass_q) &&
                     (w0_q[30:7] == vsid) && (w0_q[5:0] == pgidx[15:10]);
  assign new_w1    = keep_q | (32'd1 << PTE_REF) | (wr_q ? (32'd1 << PTE_CHG) : 32'd0);
  assign granted   = wr_q ? can_wr : can_rd;
  assign word_addr = group_addr + {{(30-IDX_W){1'b0}}, idx_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ea_q <= '0; seg_q <= '0; tr_q <= '0; w0_q <= '0; keep_q <= '0;
      wb_addr_q <= '0; wb_data_q <= '0; ra_q <= '0;
      wr_q <= 1'b0; fetch_q <= 1'b0; user_q <= 1'b0; pass_q <= 1'b0;
      hit_q <= 1'b0; multi_q <= 1'b0; pr_q <= 1'b0; pw_q <= 1'b0;
      idx_q <= '0; slot_q <= '0; fault_q <= FLT_NONE;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          ea_q <= req_addr; wr_q <= req_write; fetch_q <= req_fetch;
          user_q <= req_user; seg_q <= seg_rd; tr_q <= table_reg;
          pass_q <= 1'b0; idx_q <= '0; hit_q <= 1'b0; multi_q <= 1'b0;
          ra_q <= '0; pr_q <= 1'b0; pw_q <= 1'b0;
          if (seg_rd[SEG_DIRECT]) begin
            fault_q <= FLT_DSEG; state <= S_DONE;
          end else if (req_fetch && seg_rd[SEG_NOEXEC]) begin
            fault_q <= FLT_NOEXEC; state <= S_DONE;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: state <= S_WAIT;
        S_WAIT: begin
          if (!idx_q[0]) begin
            w0_q <= mem_rdata;
          end else if (entry_hit) begin
            if (!hit_q) begin
              hit_q  <= 1'b1;
              keep_q <= mem_rdata;
              slot_q <= idx_q[IDX_W-1:1];
            end else if ((keep_q & AGREE_MASK) != (mem_rdata & AGREE_MASK)) begin
              multi_q <= 1'b1;
            end
          end
          idx_q <= idx_q + 1'b1;
          state <= (idx_q == LAST_WORD) ? S_EVAL : S_RD;
        end
        S_EVAL: begin
          if (multi_q) begin
            fault_q <= FLT_MULTI; state <= S_DONE;
          end else if (!hit_q) begin
            if (!pass_q) begin
              pass_q <= 1'b1; idx_q <= '0; state <= S_RD;
            end else begin
              fault_q <= FLT_MISS; state <= S_DONE;
            end
          end else if (!granted) begin
            fault_q <= FLT_PROT; state <= S_DONE;
          end else begin
            fault_q   <= FLT_NONE;
            ra_q      <= {keep_q[31:12], ea_q[11:0]};
            pr_q      <= can_rd;
            pw_q      <= can_wr & new_w1[PTE_CHG];
            wb_data_q <= new_w1;
            wb_addr_q <= group_addr + {{(29-SLOT_W){1'b0}}, slot_q, 3'b000} + 32'd4;
            state     <= (new_w1 != keep_q) ? S_WB : S_DONE;
          end
        end
        S_WB:   state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign fault      = fault_q;
  assign real_addr  = ra_q;
  assign perm_read  = pr_q;
  assign perm_write = pw_q;
  assign mem_rd_en  = (state == S_RD);
  assign mem_wr_en  = (state == S_WB);
  assign mem_addr   = (state == S_WB) ? wb_addr_q : word_addr;
  assign mem_wdata  = wb_data_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  wb_ref_chk: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> mem_wdata[PTE_REF]);
  // R9
  wb_then_done_chk: assert property (@(posedge clk) disable iff (rst) mem_wr_en |=> done);
  // R3
  noexec_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 3'd3) |-> fetch_q);
  // R10
  write_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 3'd0 && wr_q) |-> perm_write);
  // R5
  miss_second_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 3'd1) |-> pass_q);
  // R2
  dseg_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en) |-> !seg_q[SEG_DIRECT]);
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seg_wr_en = 1'b0;
  logic [3:0] seg_wr_idx = '0;
  logic [31:0] seg_wr_data = '0;
  logic [31:0] tr = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic busy, done, perm_read, perm_write, mem_rd_en, mem_wr_en;
  logic [2:0] fault;
  logic [31:0] real_addr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_data = '0;
  logic [31:0] mem [0:16383];
  logic [31:0] segs_m [0:15];
  int wr_cnt = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker dut_i (
    .clk(clk), .rst(rst), .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
    .seg_wr_data(seg_wr_data), .table_reg(tr), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
    .req_user(req_user), .busy(busy), .done(done), .fault(fault),
    .real_addr(real_addr), .perm_read(perm_read), .perm_write(perm_write),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[15:2]];
    if (mem_wr_en) begin
      mem[mem_addr[15:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (tb_we) begin
      mem[tb_addr[15:2]] <= tb_data;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_seg(input int i, input logic [31:0] d);
    seg_wr_en = 1'b1; seg_wr_idx = i[3:0]; seg_wr_data = d;
    @(negedge clk);
    seg_wr_en = 1'b0;
    segs_m[i] = d;
  endtask

  function automatic logic [31:0] grp(input logic [23:0] vs, input logic [15:0] pg, input int p);
    logic [31:0] h, msk;
    h = ((({8'h00, vs}) ^ {16'h0000, pg}) & 32'h0007_FFFF) << 6;
    if (p == 1) h = ~h & 32'h01FF_FFC0;
    msk = ({23'b0, tr[8:0]} << 16) | 32'h0000_FFC0;
    return (tr & 32'hFFFF_0000) | (h & msk);
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] ea, input int sel);
    logic [31:0] s;
    s = segs_m[ea[31:28]];
    return {1'b1, s[23:0], sel[0], ea[27:22]};
  endfunction

  task automatic ref_walk(input logic [31:0] ea, input bit wr, input bit fe, input bit us,
                          output logic [2:0] f, output logic [31:0] ra, output bit pr,
                          output bit pw, output bit wb, output logic [31:0] wba,
                          output logic [31:0] wbd);
    logic [31:0] s, g, a, w0, w1, keep, nw, sa;
    bit key, found, multi, prp, pwp;
    s = segs_m[ea[31:28]];
    f = 3'd0; ra = '0; pr = 0; pw = 0; wb = 0; wba = '0; wbd = '0;
    keep = '0; sa = '0; found = 0; multi = 0;
    key = us ? s[29] : s[30];
    if (s[31]) begin f = 3'd4; return; end
    if (fe && s[28]) begin f = 3'd3; return; end
    for (int p = 0; p < 2; p++) begin
      if (!found) begin
        g = grp(s[23:0], ea[27:12], p);
        for (int e = 0; e < 8; e++) begin
          a  = g + 32'(e * 8);
          w0 = mem[a[15:2]];
          w1 = mem[a[15:2] + 14'd1];
          if (w0 == {1'b1, s[23:0], p[0], ea[27:22]}) begin
            if (!found) begin found = 1; keep = w1; sa = a + 32'd4; end
            else if ((keep & 32'hFFFF_F07B) != (w1 & 32'hFFFF_F07B)) multi = 1;
          end
        end
      end
    end
    if (!found) begin f = 3'd1; return; end
    if (multi) begin f = 3'd5; return; end
    case ({key, keep[1:0]})
      3'b000, 3'b001, 3'b010: begin prp = 1; pwp = 1; end
      3'b011:                 begin prp = 1; pwp = 0; end
      3'b100:                 begin prp = 0; pwp = 0; end
      3'b110:                 begin prp = 1; pwp = 1; end
      default:                begin prp = 1; pwp = 0; end
    endcase
    if (wr ? !pwp : !prp) begin f = 3'd2; return; end
    nw = keep | 32'h0000_0100 | (wr ? 32'h0000_0080 : 32'h0);
    ra = {keep[31:12], ea[11:0]};
    pr = prp; pw = pwp & nw[7];
    wb = (nw != keep); wba = sa; wbd = nw;
  endtask

  task automatic walk(input logic [31:0] ea, input bit wr, input bit fe, input bit us,
                      input int exp_f, input string rq, input bit inject);
    logic [2:0] ef; logic [31:0] era, ewba, ewbd; bit epr, epw, ewb;
    int base, n, extra;
    ref_walk(ea, wr, fe, us, ef, era, epr, epw, ewb, ewba, ewbd);
    if (exp_f >= 0) chk(rq, "model fault", 32'(ef), 32'(exp_f));
    base = wr_cnt;
    req_valid = 1'b1; req_addr = ea; req_write = wr; req_fetch = fe; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (inject && n == 3) begin req_valid = 1'b1; req_addr = ea ^ 32'h0000_1000; end
      if (inject && n == 4) req_valid = 1'b0;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 done actual=timeout expected=pulse");
      return;
    end
    chk(rq, "fault", 32'(fault), 32'(ef));
    if (ef == 3'd0) begin
      chk(rq, "real_addr R11", real_addr, era);
      chk(rq, "perm_read", 32'(perm_read), 32'(epr));
      chk(rq, "perm_write", 32'(perm_write), 32'(epw));
    end
    @(negedge clk);
    chk(rq, "writeback count R9", 32'(wr_cnt - base), 32'(ewb));
    if (ewb) chk(rq, "written word R9", mem[ewba[15:2]], ewbd);
    if (inject) begin
      extra = 0;
      for (int k = 0; k < 40; k++) begin
        if (done) extra++;
        @(negedge clk);
      end
      chk("R12", "extra done pulses", 32'(extra), 32'd0);
    end
  endtask

  task automatic clean(input logic [31:0] ea);
    logic [31:0] s, g;
    s = segs_m[ea[31:28]];
    for (int p = 0; p < 2; p++) begin
      g = grp(s[23:0], ea[27:12], p);
      for (int e = 0; e < 16; e++) poke(g + 32'(e * 4), 32'h0);
    end
  endtask

  task automatic plant(input logic [31:0] ea, input int p, input int slot, input int sel,
                       input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] s, g;
    s = segs_m[ea[31:28]];
    g = grp(s[23:0], ea[27:12], p) + 32'(slot * 8);
    poke(g, w0);
    poke(g + 32'd4, w1);
    if (sel < 0) return;
  endtask

  task automatic rnd_fill(input logic [31:0] ea);
    logic [31:0] s, g, w0;
    s = segs_m[ea[31:28]];
    for (int p = 0; p < 2; p++) begin
      g = grp(s[23:0], ea[27:12], p);
      for (int e = 0; e < 8; e++) begin
        case ($urandom % 4)
          0: w0 = $urandom & 32'h7FFF_FFFF;
          1: w0 = tag_of(ea, 1 - p);
          2: w0 = tag_of(ea, p) & 32'h7FFF_FFFF;
          default: w0 = $urandom;
        endcase
        poke(g + 32'(e * 8), w0);
        poke(g + 32'(e * 8) + 32'd4, $urandom);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ea, s, w1a;
    int mode, sl, sl2;
    bit wr, fe, us;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) segs_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "busy after reset", 32'(busy), 32'd0);
    chk("R12", "done after reset", 32'(done), 32'd0);
    chk("R12", "mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    chk("R12", "mem_wr_en after reset", 32'(mem_wr_en), 32'd0);
    tr = 32'h0000_0000;

    // R11 R9 R10: read with R and C clear
    set_seg(0, 32'h0000_0123);
    ea = 32'h0ABC_D123;
    clean(ea);
    plant(ea, 0, 3, 0, tag_of(ea, 0), 32'h5555_5002);
    walk(ea, 0, 0, 0, 0, "R11", 0);
    chk("R11", "literal real_addr", real_addr, 32'h5555_5123);
    chk("R10", "no write perm while C clear", 32'(perm_write), 32'd0);
    // R9: write sets C
    walk(ea, 1, 0, 0, 0, "R9", 0);
    chk("R10", "write perm after write", 32'(perm_write), 32'd1);
    // R9: nothing changes, no write-back
    walk(ea, 0, 0, 0, 0, "R9", 0);
    // R12: request while busy ignored
    walk(ea, 0, 0, 0, 0, "R12", 1);

    // R5: secondary hit with a wrong-selector distractor in primary (R6)
    set_seg(1, 32'h0000_0ABC);
    ea = 32'h1234_5678;
    clean(ea);
    plant(ea, 0, 2, 1, tag_of(ea, 1), 32'h0000_7002);
    plant(ea, 1, 7, 1, tag_of(ea, 1), 32'h0ABC_D002);
    walk(ea, 0, 0, 1, 0, "R5", 0);
    chk("R5", "secondary real_addr", real_addr, 32'h0ABC_D678);
    // R5: full miss
    clean(ea);
    walk(ea, 0, 0, 1, 1, "R5", 0);

    // R7 R1: user key with pp=0
    set_seg(2, 32'h2000_0456);
    ea = 32'h2000_5000;
    clean(ea);
    plant(ea, 0, 0, 0, tag_of(ea, 0), 32'h1234_5000);
    walk(ea, 0, 0, 1, 2, "R1", 0);
    walk(ea, 0, 0, 0, 0, "R1", 0);
    // R7: supervisor key, pp=1
    set_seg(3, 32'h4000_0789);
    ea = 32'h3111_1ABC;
    clean(ea);
    plant(ea, 0, 5, 0, tag_of(ea, 0), 32'h0000_A001);
    walk(ea, 1, 0, 0, 2, "R7", 0);
    walk(ea, 0, 0, 0, 0, "R7", 0);
    chk("R7", "read-only pp=1 key 1", 32'(perm_write), 32'd0);
    // R7: key 0, pp=3 write denied
    set_seg(4, 32'h0000_0042);
    ea = 32'h4000_9000;
    clean(ea);
    plant(ea, 0, 6, 0, tag_of(ea, 0), 32'h0000_B003);
    walk(ea, 1, 0, 1, 2, "R7", 0);

    // R8: conflicting duplicates, then duplicates differing only in bit 7
    set_seg(5, 32'h0000_0777);
    ea = 32'h5002_2000;
    clean(ea);
    plant(ea, 0, 1, 0, tag_of(ea, 0), 32'h0000_1000);
    plant(ea, 0, 4, 0, tag_of(ea, 0), 32'h0000_2000);
    walk(ea, 0, 0, 0, 5, "R8", 0);
    clean(ea);
    plant(ea, 0, 1, 0, tag_of(ea, 0), 32'h0000_1000);
    plant(ea, 0, 4, 0, tag_of(ea, 0), 32'h0000_1080);
    walk(ea, 0, 0, 0, 0, "R8", 0);

    // R3: no-execute segment
    set_seg(6, 32'h1000_0999);
    ea = 32'h6000_3000;
    clean(ea);
    plant(ea, 0, 0, 0, tag_of(ea, 0), 32'h0000_C002);
    walk(ea, 0, 1, 0, 3, "R3", 0);
    walk(ea, 0, 0, 0, 0, "R3", 0);

    // R2: direct-store segment
    set_seg(7, 32'h8000_0000);
    walk(32'h7000_0000, 0, 0, 0, 4, "R2", 0);
    walk(32'h7000_0000, 0, 1, 1, 4, "R2", 0);

    // R6: right tag but valid clear
    set_seg(8, 32'h0000_0111);
    ea = 32'h8000_4000;
    clean(ea);
    plant(ea, 0, 2, 0, tag_of(ea, 0) & 32'h7FFF_FFFF, 32'h0000_D002);
    walk(ea, 0, 0, 0, 1, "R6", 0);

    // R4: constrained random rounds
    for (int it = 0; it < 150; it++) begin
      s = {($urandom % 16 == 0), 1'($urandom), 1'($urandom), ($urandom % 8 == 0),
           4'h0, 24'($urandom)};
      sl = $urandom % 16;
      set_seg(sl, s);
      tr = {16'($urandom), 7'b0, 9'($urandom)};
      ea = {sl[3:0], 28'($urandom)};
      rnd_fill(ea);
      mode = $urandom % 4;
      sl2 = $urandom % 8;
      w1a = $urandom;
      if (mode == 1 || mode == 3) plant(ea, 0, sl2, 0, tag_of(ea, 0), w1a);
      if (mode == 2) plant(ea, 1, sl2, 1, tag_of(ea, 1), w1a);
      if (mode == 3) plant(ea, 0, (sl2 + 3) % 8, 0, tag_of(ea, 0),
                           ($urandom % 2) ? (w1a ^ 32'h0000_0184) : (w1a ^ 32'h0000_1000));
      fe = ($urandom % 4 == 0);
      wr = fe ? 1'b0 : 1'($urandom);
      us = 1'($urandom);
      walk(ea, wr, fe, us, -1, "R4", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule